// File: doc/BRIEF.md
# Physical Address Decoder with Alignment Faults

The block takes one memory request per handshake (a physical address, an access size and a read/write flag) and decides where that request may go. An address can select the RAM region, the read-only ROM window or the console I/O window. An address can also fault. A fault happens when the access is misaligned for its size, when the address is not mapped, or when a store targets the ROM window. A request that decodes cleanly returns one region select and the offset of the address inside that region. A request that faults returns a load-side or a store-side address-error flag, together with the address that caused it.

The decode result is registered and returned as a response one cycle after the request is accepted. The response carries an `ok` flag. Follow-on actions, such as invalidating a cache line after a store, must be gated with that flag, so that they happen only for accesses that did not raise an exception. The region bounds are parameters. When windows overlap, RAM wins over ROM and ROM wins over console.

Both sides use valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. A response transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. The block holds at most one response. It is ready for a new request whenever its response register is empty, or whenever that register is being drained in the same cycle. A stalled response stays unchanged until it is taken. The requester must hold its request stable while `req_valid` is high and `req_ready` is low.

Top module: `pad_addr_decoder`

## Requirements
- R1: A word access (`req_size` 2'b10, and also 2'b11) whose address has either of bits [1:0] set faults. It selects no region.
- R2: A halfword access (`req_size` 2'b01) with address bit 0 set faults, for loads and stores alike. A byte access (`req_size` 2'b00) never faults for alignment.
- R3: An aligned access whose address is at or below `RAM_HI` selects RAM, for loads and stores, with `rsp_offset` equal to the address minus `RAM_LO`. The RAM check is made before any other window.
- R4: An aligned load inside [`ROM_LO`, `ROM_HI`] selects ROM, with `rsp_offset` equal to the address minus `ROM_LO`. An aligned store inside that window faults and selects nothing.
- R5: An aligned access inside [`CON_LO`, `CON_HI`] selects the console for loads and stores, with `rsp_offset` equal to the address minus `CON_LO`.
- R6: An aligned access that matches no window faults.
- R7: A faulting load raises `rsp_load_err`, and a faulting store raises `rsp_store_err`. Only one of the two is raised per response. `rsp_bad_addr` carries the request address on a fault and is zero otherwise. All result outputs are zero while `rsp_valid` is low.
- R8: `rsp_ok` is high exactly when a valid response has no fault. In that case exactly one region select is high. A faulting response has every select low and a zero offset.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. Each accepted request yields exactly one response, visible after the next clock edge. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.
- R10: While `rst_n` is low, `rsp_valid` and every result output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | Physical address |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_write | input | 1 | 1 store, 0 load |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_sel_ram | output | 1 | RAM selected |
| rsp_sel_rom | output | 1 | ROM selected |
| rsp_sel_con | output | 1 | Console selected |
| rsp_offset | output | AW | Region-relative offset |
| rsp_ok | output | 1 | Access completed without exception |
| rsp_load_err | output | 1 | Load address error |
| rsp_store_err | output | 1 | Store address error |
| rsp_bad_addr | output | AW | Faulting address |

## Verification
The hardest situation to reach from the ports is a response that stalls while the next request is already waiting. In that state the register must hold its value and refuse the new request. Only after the stall clears may it take the next one in the same cycle as the drain. The stimulus drops `rsp_ready` on about a quarter of cycles and keeps `req_valid` high on most cycles. Stalls therefore collide with pending requests often.

Directed requests place addresses exactly on every window edge. They also cover a store into ROM at a byte size, odd halfword loads and stores, and odd byte accesses. Random addresses are then biased towards each window and its bounds.

// File: rtl/pad_pkg.sv
package pad_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic ram;
    logic rom;
    logic con;
  } region_sel_t;
endpackage

// File: rtl/pad_align_chk.sv
module pad_align_chk
  import pad_pkg::*;
(
  input  logic [1:0] size,
  input  logic [1:0] addr_lsb,
  output logic       misaligned
);
  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addr_lsb[0];
      default: misaligned = |addr_lsb;
    endcase
  end
endmodule

// File: rtl/pad_region_dec.sv
module pad_region_dec
  import pad_pkg::*;
#(
  parameter int unsigned   AW     = 32,
  parameter logic [AW-1:0] RAM_LO = '0,
  parameter logic [AW-1:0] RAM_HI = '1,
  parameter logic [AW-1:0] ROM_LO = '0,
  parameter logic [AW-1:0] ROM_HI = '0,
  parameter logic [AW-1:0] CON_LO = '0,
  parameter logic [AW-1:0] CON_HI = '0
) (
  input  logic [AW-1:0] addr,
  input  logic          is_write,
  output region_sel_t   sel,
  output logic [AW-1:0] offset,
  output logic          mapped
);
  logic hit_ram, hit_rom, hit_con;

  assign hit_ram = (addr <= RAM_HI);
  assign hit_rom = (addr >= ROM_LO) && (addr <= ROM_HI);
  assign hit_con = (addr >= CON_LO) && (addr <= CON_HI);

  always_comb begin
    sel    = '0;
    offset = '0;
    mapped = 1'b0;
    if (hit_ram) begin
      sel.ram = 1'b1;
      offset  = addr - RAM_LO;
      mapped  = 1'b1;
    end else if (hit_rom) begin
      // ROM window is read-only: a store here is left unmapped
      if (!is_write) begin
        sel.rom = 1'b1;
        offset  = addr - ROM_LO;
        mapped  = 1'b1;
      end
    end else if (hit_con) begin
      sel.con = 1'b1;
      offset  = addr - CON_LO;
      mapped  = 1'b1;
    end
  end
endmodule

// File: rtl/pad_rsp_reg.sv
module pad_rsp_reg
  import pad_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  region_sel_t   in_sel,
  input  logic [AW-1:0] in_offset,
  input  logic          in_ok,
  input  logic          in_lerr,
  input  logic          in_serr,
  input  logic [AW-1:0] in_bad,
  output logic          out_valid,
  input  logic          out_ready,
  output region_sel_t   out_sel,
  output logic [AW-1:0] out_offset,
  output logic          out_ok,
  output logic          out_lerr,
  output logic          out_serr,
  output logic [AW-1:0] out_bad
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sel    <= '0;
      out_offset <= '0;
      out_ok     <= 1'b0;
      out_lerr   <= 1'b0;
      out_serr   <= 1'b0;
      out_bad    <= '0;
    end else if (in_ready) begin
      // an empty slot is cleared so result pins read zero when idle
      out_valid  <= in_valid;
      out_sel    <= in_valid ? in_sel    : '0;
      out_offset <= in_valid ? in_offset : '0;
      out_ok     <= in_valid & in_ok;
      out_lerr   <= in_valid & in_lerr;
      out_serr   <= in_valid & in_serr;
      out_bad    <= in_valid ? in_bad    : '0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sel) && $stable(out_offset)
      && $stable(out_ok) && $stable(out_lerr) && $stable(out_serr) && $stable(out_bad)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_ok && !out_lerr && !out_serr && out_sel == '0 && out_bad == '0); // R7
endmodule

// File: rtl/pad_addr_decoder.sv
module pad_addr_decoder
  import pad_pkg::*;
#(
  parameter int unsigned   AW     = 32,
  parameter logic [AW-1:0] RAM_LO = 32'h0000_0000,
  parameter logic [AW-1:0] RAM_HI = 32'h0000_FFFF,
  parameter logic [AW-1:0] ROM_LO = 32'h1FC0_0000,
  parameter logic [AW-1:0] ROM_HI = 32'h1FC0_3FFF,
  parameter logic [AW-1:0] CON_LO = 32'h1F00_0000,
  parameter logic [AW-1:0] CON_HI = 32'h1F00_000F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_sel_ram,
  output logic          rsp_sel_rom,
  output logic          rsp_sel_con,
  output logic [AW-1:0] rsp_offset,
  output logic          rsp_ok,
  output logic          rsp_load_err,
  output logic          rsp_store_err,
  output logic [AW-1:0] rsp_bad_addr
);
  logic          misaligned, mapped, fault;
  region_sel_t   dec_sel, res_sel, out_sel;
  logic [AW-1:0] dec_offset;

  pad_align_chk u_align (
    .size       (req_size),
    .addr_lsb   (req_addr[1:0]),
    .misaligned (misaligned)
  );

  pad_region_dec #(
    .AW(AW), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .ROM_LO(ROM_LO),
    .ROM_HI(ROM_HI), .CON_LO(CON_LO), .CON_HI(CON_HI)
  ) u_region (
    .addr     (req_addr),
    .is_write (req_write),
    .sel      (dec_sel),
    .offset   (dec_offset),
    .mapped   (mapped)
  );

  // alignment is judged before any region is touched
  assign fault   = misaligned || !mapped;
  assign res_sel = fault ? '0 : dec_sel;

  pad_rsp_reg #(.AW(AW)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ready   (req_ready),
    .in_sel     (res_sel),
    .in_offset  (fault ? '0 : dec_offset),
    .in_ok      (!fault),
    .in_lerr    (fault && !req_write),
    .in_serr    (fault && req_write),
    .in_bad     (fault ? req_addr : '0),
    .out_valid  (rsp_valid),
    .out_ready  (rsp_ready),
    .out_sel    (out_sel),
    .out_offset (rsp_offset),
    .out_ok     (rsp_ok),
    .out_lerr   (rsp_load_err),
    .out_serr   (rsp_store_err),
    .out_bad    (rsp_bad_addr)
  );

  assign rsp_sel_ram = out_sel.ram;
  assign rsp_sel_rom = out_sel.rom;
  assign rsp_sel_con = out_sel.con;

  logic req_in_rom;
  assign req_in_rom = (req_addr > RAM_HI) && (req_addr >= ROM_LO) && (req_addr <= ROM_HI);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_sel_ram, rsp_sel_rom, rsp_sel_con})); // R8

  AST_OK_MEANS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_ok == ($countones({rsp_sel_ram, rsp_sel_rom, rsp_sel_con}) == 1)); // R8

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ok ^ (rsp_load_err | rsp_store_err)) && !(rsp_load_err && rsp_store_err)); // R7

  AST_ROM_STORE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && req_in_rom |=> rsp_valid && rsp_store_err && !rsp_sel_rom); // R4

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R9
endmodule

// File: tb/test_pad_addr_decoder.sv
module test_pad_addr_decoder;
  localparam logic [31:0] RAM_LO = 32'h0000_0000;
  localparam logic [31:0] RAM_HI = 32'h0000_FFFF;
  localparam logic [31:0] ROM_LO = 32'h1FC0_0000;
  localparam logic [31:0] ROM_HI = 32'h1FC0_3FFF;
  localparam logic [31:0] CON_LO = 32'h1F00_0000;
  localparam logic [31:0] CON_HI = 32'h1F00_000F;
  localparam int N_REQ = 2000;
  localparam int N_DIR = 14;

  typedef struct packed {
    logic        ram, rom, con, ok, lerr, serr;
    logic [31:0] off, bad;
  } exp_t;

  logic clk = 1'b0, rst_n;
  logic req_valid, req_ready, req_write, rsp_valid, rsp_ready;
  logic [31:0] req_addr, rsp_offset, rsp_bad_addr;
  logic [1:0]  req_size;
  logic rsp_sel_ram, rsp_sel_rom, rsp_sel_con, rsp_ok, rsp_load_err, rsp_store_err;

  int checks = 0, fails = 0;
  exp_t  q[$];
  string qtag[$];

  always #5 clk = ~clk;

  pad_addr_decoder #(
    .AW(32), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .ROM_LO(ROM_LO),
    .ROM_HI(ROM_HI), .CON_LO(CON_LO), .CON_HI(CON_HI)
  ) i_pad_addr_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_sel_ram(rsp_sel_ram),
    .rsp_sel_rom(rsp_sel_rom), .rsp_sel_con(rsp_sel_con), .rsp_offset(rsp_offset),
    .rsp_ok(rsp_ok), .rsp_load_err(rsp_load_err), .rsp_store_err(rsp_store_err),
    .rsp_bad_addr(rsp_bad_addr)
  );

  function automatic exp_t model(input logic [31:0] a, input logic [1:0] sz,
                                 input logic wr, output string tag);
    exp_t e = '0;
    logic mis = (sz >= 2'd2 && a[1:0] != 2'b00) || (sz == 2'd1 && a[0]);
    logic flt = 1'b0;
    if (mis) begin
      flt = 1'b1; tag = (sz == 2'd1) ? "R2" : "R1";
    end else if (a <= RAM_HI) begin
      e.ram = 1'b1; e.off = a - RAM_LO; tag = (sz == 2'd0) ? "R2/R3" : "R3";
    end else if (a >= ROM_LO && a <= ROM_HI) begin
      tag = "R4";
      if (wr) flt = 1'b1;
      else begin e.rom = 1'b1; e.off = a - ROM_LO; end
    end else if (a >= CON_LO && a <= CON_HI) begin
      e.con = 1'b1; e.off = a - CON_LO; tag = "R5";
    end else begin
      flt = 1'b1; tag = "R6";
    end
    if (flt) begin e.lerr = !wr; e.serr = wr; e.bad = a; end
    else e.ok = 1'b1;
    return e;
  endfunction

  function automatic exp_t observed();
    exp_t o;
    o.ram = rsp_sel_ram; o.rom = rsp_sel_rom; o.con = rsp_sel_con; o.ok = rsp_ok;
    o.lerr = rsp_load_err; o.serr = rsp_store_err; o.off = rsp_offset; o.bad = rsp_bad_addr;
    return o;
  endfunction

  task automatic check(input logic good, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic pick_random(output logic [31:0] a);
    case ($urandom_range(0, 4))
      0: a = $urandom_range(0, RAM_HI);
      1: a = ROM_LO + $urandom_range(0, ROM_HI - ROM_LO);
      2: a = CON_LO + $urandom_range(0, CON_HI - CON_LO);
      3: case ($urandom_range(0, 9))
           0: a = RAM_HI;     1: a = RAM_HI + 1;  2: a = ROM_LO - 1; 3: a = ROM_LO;
           4: a = ROM_HI;     5: a = ROM_HI + 1;  6: a = CON_LO - 1; 7: a = CON_LO;
           8: a = CON_HI;     default: a = CON_HI + 1;
         endcase
      default: a = $urandom();
    endcase
  endtask

  logic [31:0] d_addr [N_DIR];
  logic [1:0]  d_size [N_DIR];
  logic        d_wr   [N_DIR];
  bit done = 0;

  initial begin
    d_addr = '{32'h4, 32'h2, 32'h3, 32'h5, 32'h1, RAM_HI, RAM_HI + 1, ROM_LO,
               ROM_LO + 8, ROM_HI, CON_LO, CON_HI, 32'h2000_0000, ROM_LO + 1};
    d_size = '{2'd2, 2'd2, 2'd1, 2'd0, 2'd1, 2'd0, 2'd2, 2'd2,
               2'd2, 2'd0, 2'd2, 2'd0, 2'd2, 2'd0};
    d_wr   = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
               1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  end

  initial begin
    int sent = 0;
    bit acc = 0;
    string tag;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    rsp_ready = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!rsp_valid && observed() == '0, "R10", "reset outputs",
              {rsp_valid, observed()}, '0);
        rst_n = 1'b1;
        while (sent < N_REQ || q.size() != 0) begin
          @(negedge clk);
          check(rsp_valid == (q.size() != 0), "R9", "one response per request",
                rsp_valid, q.size() != 0);
          if (rsp_valid)
            check(observed() == q[0], qtag[0], "response fields", observed(), q[0]);
          else
            check(observed() == '0, "R7", "idle outputs zero", observed(), '0);
          if (rsp_valid)
            check(rsp_ok == (rsp_sel_ram + rsp_sel_rom + rsp_sel_con == 1), "R8",
                  "ok vs select", rsp_ok, !rsp_ok);
          if (acc) req_valid = 1'b0;
          acc = 0;
          rsp_ready = ($urandom_range(0, 3) != 0);
          if (!req_valid && sent < N_REQ && $urandom_range(0, 4) != 0) begin
            if (sent < N_DIR) begin
              req_addr = d_addr[sent]; req_size = d_size[sent]; req_write = d_wr[sent];
            end else begin
              pick_random(req_addr);
              req_size = 2'($urandom_range(0, 3));
              req_write = 1'($urandom_range(0, 1));
            end
            req_valid = 1'b1;
          end
          #1;
          check(req_ready == (!rsp_valid || rsp_ready), "R9", "ready rule",
                req_ready, !rsp_valid || rsp_ready);
          if (rsp_valid && rsp_ready) begin void'(q.pop_front()); void'(qtag.pop_front()); end
          if (req_valid && req_ready) begin
            q.push_back(model(req_addr, req_size, req_write, tag));
            qtag.push_back(tag);
            sent++; acc = 1;
          end
        end
        done = 1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) check(1'b0, "R9", "watchdog expired", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule